// File: doc/BRIEF.md
# Parallel Tree Reduction Sequencer

This block folds a bank of partial-sum registers, one per lane, into a single total. A start pulse, taken while the block is idle, captures all lane words from a wide parallel input in one cycle. The block then runs a series of reduction steps. In each step every active low lane adds the word held by a partner lane in the upper part of the active range. The next step cannot begin until every lane has committed its result for the current step. When one active lane is left, the total sits in lane 0 and is shown on the result port.

Two schedules are available and a parameter picks one of them. With the floor-halving schedule, an odd active count is handled first: lane 0 absorbs the unpaired top element, and then the count is halved downward. With the ceiling-halving schedule, senders sit at or above the rounded-up half point, and a lane with no partner simply holds its value. Each step takes one clock cycle. All adds in a step read the old bank and write the new bank together. Arithmetic is two's complement and wraps on overflow.

Top module: `tree_reduce_seq`

## Requirements
- R1: After reset, busy_o and done_o are 0.
- R2: A start_i pulse while busy_o is 0 captures load_i (lane k in bits [k*WIDTH +: WIDTH]), and busy_o is 1 in the next cycle.
- R3: When the run ends, sum_o equals the sum of all captured lane words, taken modulo 2^WIDTH.
- R4: With SCHED=0 (floor halving), busy_o stays high for exactly the number of steps needed to take the count from LANES to 1 by count := count/2 (one step if LANES is 1). That is 6 steps for 100 lanes and 2 steps for 7 lanes.
- R5: With SCHED=0, whenever the active count c is odd and above 1, lane 0 adds lane c-1 in that same step. Words placed only in such leftover lanes therefore still reach the total.
- R6: With SCHED=1 (ceiling halving), lane i below c/2 (rounded down) adds lane i+ceil(c/2), and the count becomes ceil(c/2). That is 3 steps for 7 lanes.
- R7: done_o is a one-cycle pulse. It is asserted in the cycle in which busy_o first reads 0 after a run.
- R8: A start_i pulse while busy_o is 1 is ignored. The run keeps its length and its total.
- R9: While the block is idle and start_i is low, sum_o holds its value.
- R10: Overflow wraps. For example, 100 lanes of 32'h7FFFFFFF sum to 32'hFFFFFF9C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; taken only when idle |
| load_i | input | LANES*WIDTH | Initial partial sums, lane k at bits [k*WIDTH +: WIDTH] |
| busy_o | output | 1 | Reduction in progress |
| done_o | output | 1 | One-cycle pulse at end of run |
| sum_o | output | WIDTH | Lane 0 value; the total once done_o has pulsed |

## Verification
The properties assume that start_i has a known value in every cycle after reset. They allow start_i to be raised while busy, and that case has its own check. The run-length bound assumes the block has been out of reset for at least one cycle. The stimulus drives start_i and load_i only on the falling edge, and it keeps start_i high for exactly one cycle per request. Every request that arrives mid-run is raised while busy_o reads 1, so no request is ever partly taken.

// File: rtl/trs_pkg.sv
package trs_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } trs_state_e;

   localparam int SCHED_FLOOR = 0;
   localparam int SCHED_CEIL  = 1;

   function automatic int cnt_width(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/trs_schedule.sv
module trs_schedule
   import trs_pkg::*;
#(
   parameter int SCHED = SCHED_FLOOR,
   parameter int CW    = 7
) (
   input  logic [CW-1:0] count_i,
   output logic [CW-1:0] pair_off_o,
   output logic [CW-1:0] recv_lim_o,
   output logic          fold_en_o,
   output logic [CW-1:0] fold_idx_o,
   output logic [CW-1:0] next_count_o,
   output logic          last_o
);

   logic [CW:0] count_inc;

   assign count_inc  = {1'b0, count_i} + {{CW{1'b0}}, 1'b1};
   assign recv_lim_o = count_i >> 1;
   assign last_o     = (next_count_o <= {{(CW-1){1'b0}}, 1'b1});

   generate
      if (SCHED == SCHED_FLOOR) begin : g_floor
         assign pair_off_o   = count_i >> 1;
         assign fold_en_o    = count_i[0] && (count_i > {{(CW-1){1'b0}}, 1'b1});
         assign fold_idx_o   = count_i - {{(CW-1){1'b0}}, 1'b1};
         assign next_count_o = (count_i > {{(CW-1){1'b0}}, 1'b1}) ?
                               (count_i >> 1) : {{(CW-1){1'b0}}, 1'b1};
      end else begin : g_ceil
         assign pair_off_o   = count_inc[CW:1];
         assign fold_en_o    = 1'b0;
         assign fold_idx_o   = '0;
         assign next_count_o = count_inc[CW:1];
      end
   endgenerate

endmodule

// File: rtl/trs_partner_shift.sv
module trs_partner_shift #(
   parameter int LANES = 100,
   parameter int WIDTH = 32,
   parameter int CW    = 7
) (
   input  logic [LANES-1:0][WIDTH-1:0] bank_i,
   input  logic [CW-1:0]               off_i,
   output logic [LANES-1:0][WIDTH-1:0] part_o
);

   logic [CW:0][LANES-1:0][WIDTH-1:0] stg;

   assign stg[0] = bank_i;

   generate
      for (genvar s = 0; s < CW; s++) begin : g_stage
         for (genvar i = 0; i < LANES; i++) begin : g_lane
            localparam int SRC = i + (1 << s);
            if (SRC < LANES) begin : g_in
               assign stg[s+1][i] = off_i[s] ? stg[s][SRC] : stg[s][i];
            end else begin : g_edge
               assign stg[s+1][i] = off_i[s] ? '0 : stg[s][i];
            end
         end
      end
   endgenerate

   assign part_o = stg[CW];

endmodule

// File: rtl/trs_lane_bank.sv
module trs_lane_bank #(
   parameter int LANES = 100,
   parameter int WIDTH = 32,
   parameter int CW    = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load_en_i,
   input  logic [LANES*WIDTH-1:0] load_i,
   input  logic                   step_en_i,
   input  logic [CW-1:0]          pair_off_i,
   input  logic [CW-1:0]          recv_lim_i,
   input  logic                   fold_en_i,
   input  logic [CW-1:0]          fold_idx_i,
   output logic [WIDTH-1:0]       lane0_o
);

   logic [LANES-1:0][WIDTH-1:0] lane_q;
   logic [LANES-1:0][WIDTH-1:0] lane_d;
   logic [LANES-1:0][WIDTH-1:0] partner;
   logic [WIDTH-1:0]            fold_val;

   trs_partner_shift #(
      .LANES(LANES), .WIDTH(WIDTH), .CW(CW)
   ) u_shift (
      .bank_i(lane_q),
      .off_i (pair_off_i),
      .part_o(partner)
   );

   always_comb begin
      fold_val = '0;
      for (int j = 0; j < LANES; j++) begin
         if (fold_en_i && (fold_idx_i == CW'(j))) fold_val = lane_q[j];
      end
   end

   always_comb begin
      for (int g = 0; g < LANES; g++) begin
         if (CW'(g) < recv_lim_i) lane_d[g] = lane_q[g] + partner[g];
         else                     lane_d[g] = lane_q[g];
      end
      lane_d[0] = lane_d[0] + fold_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         lane_q <= '0;
      else if (load_en_i) lane_q <= load_i;
      else if (step_en_i) lane_q <= lane_d;
   end

   assign lane0_o = lane_q[0];

endmodule

// File: rtl/trs_ctrl.sv
module trs_ctrl
   import trs_pkg::*;
#(
   parameter int LANES = 100,
   parameter int CW    = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [CW-1:0] next_count_i,
   input  logic          last_i,
   output logic          load_en_o,
   output logic          step_en_o,
   output logic [CW-1:0] count_o,
   output logic          busy_o,
   output logic          done_o
);

   trs_state_e state_q;
   logic [CW-1:0] count_q;
   logic          done_q;

   assign load_en_o = (state_q == ST_IDLE) && start_i;
   assign step_en_o = (state_q == ST_RUN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         count_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (load_en_o) begin
            state_q <= ST_RUN;
            count_q <= CW'(LANES);
         end else if (step_en_o) begin
            count_q <= next_count_i;
            if (last_i) begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
            end
         end
      end
   end

   assign count_o = count_q;
   assign busy_o  = (state_q == ST_RUN);
   assign done_o  = done_q;

endmodule

// File: rtl/tree_reduce_seq.sv
module tree_reduce_seq
   import trs_pkg::*;
#(
   parameter int LANES = 100,
   parameter int WIDTH = 32,
   parameter int SCHED = SCHED_FLOOR
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [LANES*WIDTH-1:0] load_i,
   output logic                   busy_o,
   output logic                   done_o,
   output logic [WIDTH-1:0]       sum_o
);

   localparam int CW = cnt_width(LANES);

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("tree_reduce_seq: LANES must be at least 1");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("tree_reduce_seq: WIDTH must be at least 1");
      end
      if (SCHED != SCHED_FLOOR && SCHED != SCHED_CEIL) begin : g_bad_sched
         $error("tree_reduce_seq: SCHED must be 0 or 1");
      end
   endgenerate

   logic [CW-1:0] count;
   logic [CW-1:0] pair_off;
   logic [CW-1:0] recv_lim;
   logic          fold_en;
   logic [CW-1:0] fold_idx;
   logic [CW-1:0] next_count;
   logic          last;
   logic          load_en;
   logic          step_en;

   trs_ctrl #(.LANES(LANES), .CW(CW)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .next_count_i(next_count),
      .last_i      (last),
      .load_en_o   (load_en),
      .step_en_o   (step_en),
      .count_o     (count),
      .busy_o      (busy_o),
      .done_o      (done_o)
   );

   trs_schedule #(.SCHED(SCHED), .CW(CW)) u_sched (
      .count_i     (count),
      .pair_off_o  (pair_off),
      .recv_lim_o  (recv_lim),
      .fold_en_o   (fold_en),
      .fold_idx_o  (fold_idx),
      .next_count_o(next_count),
      .last_o      (last)
   );

   trs_lane_bank #(.LANES(LANES), .WIDTH(WIDTH), .CW(CW)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en_i (load_en),
      .load_i    (load_i),
      .step_en_i (step_en),
      .pair_off_i(pair_off),
      .recv_lim_i(recv_lim),
      .fold_en_i (fold_en),
      .fold_idx_i(fold_idx),
      .lane0_o   (sum_o)
   );

endmodule

// File: rtl/tree_reduce_seq_chk.sv
module tree_reduce_seq_chk #(
   parameter int LANES = 100,
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             busy_o,
   input logic             done_o,
   input logic [WIDTH-1:0] sum_o
);

   localparam int RW = $clog2(LANES + 2) + 1;
   logic [RW-1:0] run_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)      run_cnt <= '0;
      else if (busy_o) run_cnt <= run_cnt + 1'b1;
      else             run_cnt <= '0;
   end

   p_idle_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> busy_o);

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_fall_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   p_hold_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(sum_o));

   p_run_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (run_cnt <= RW'(LANES)));

endmodule

bind tree_reduce_seq tree_reduce_seq_chk #(.LANES(LANES), .WIDTH(WIDTH)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start_i(start_i),
   .busy_o (busy_o),
   .done_o (done_o),
   .sum_o  (sum_o)
);

// File: tb/tree_reduce_seq_bench.sv
`timescale 1ns/1ps
module tree_reduce_seq_bench;

   localparam int W  = 32;
   localparam int NM = 100;
   localparam int NS = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic            start_m = 1'b0;
   logic [NM*W-1:0] load_m = '0;
   logic            busy_m, done_m;
   logic [W-1:0]    sum_m;

   logic            start_s = 1'b0;
   logic [NS*W-1:0] load_s = '0;
   logic            busy_f, done_f, busy_c, done_c;
   logic [W-1:0]    sum_f, sum_c;

   tree_reduce_seq #(.LANES(NM), .WIDTH(W), .SCHED(0)) u_tree_reduce_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_m), .load_i(load_m),
      .busy_o(busy_m), .done_o(done_m), .sum_o(sum_m));

   tree_reduce_seq #(.LANES(NS), .WIDTH(W), .SCHED(0)) u_small_floor (
      .clk(clk), .rst_n(rst_n), .start_i(start_s), .load_i(load_s),
      .busy_o(busy_f), .done_o(done_f), .sum_o(sum_f));

   tree_reduce_seq #(.LANES(NS), .WIDTH(W), .SCHED(1)) u_small_ceil (
      .clk(clk), .rst_n(rst_n), .start_i(start_s), .load_i(load_s),
      .busy_o(busy_c), .done_o(done_c), .sum_o(sum_c));

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic [W-1:0] dm [NM];
   logic [W-1:0] ds [NS];

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int steps_floor(input int n);
      int s = 0;
      int h = n;
      do begin s++; h = (h > 1) ? h / 2 : 1; end while (h > 1);
      return s;
   endfunction

   function automatic int steps_ceil(input int n);
      int s = 0;
      int h = n;
      do begin s++; h = (h + 1) / 2; end while (h > 1);
      return s;
   endfunction

   // Main instance run; poke_k > 0 raises start with other data at that step (R8)
   task automatic run_main(input string name, input int poke_k);
      logic [W-1:0] exp = '0;
      int S = steps_floor(NM);
      for (int i = 0; i < NM; i++) begin
         exp = exp + dm[i];
         load_m[i*W +: W] = dm[i];
      end
      @(negedge clk); start_m = 1'b1;
      @(negedge clk); start_m = 1'b0;
      chk({name, " R2 busy after start"}, W'(busy_m), 1);
      for (int k = 1; k <= S; k++) begin
         if (k == poke_k) begin
            start_m = 1'b1;
            load_m  = {NM{32'h0000_1111}};
         end
         @(negedge clk);
         start_m = 1'b0;
         if (k < S) begin
            chk({name, " R4 busy mid-run"}, W'(busy_m), 1);
            chk({name, " R7 no early done"}, W'(done_m), 0);
         end else begin
            chk({name, " R4 busy falls on last step"}, W'(busy_m), 0);
            chk({name, " R7 done pulse"}, W'(done_m), 1);
            chk({name, " R3 total"}, sum_m, exp);
         end
      end
      @(negedge clk);
      chk({name, " R7 done one cycle"}, W'(done_m), 0);
      chk({name, " R8 stays idle"}, W'(busy_m), 0);
      repeat (3) @(negedge clk);
      chk({name, " R9 sum held"}, sum_m, exp);
   endtask

   // Both small instances, same data: floor (R4/R5) and ceil (R6) schedules
   task automatic run_small(input string name);
      logic [W-1:0] exp = '0;
      int SF = steps_floor(NS);
      int SC = steps_ceil(NS);
      for (int i = 0; i < NS; i++) begin
         exp = exp + ds[i];
         load_s[i*W +: W] = ds[i];
      end
      @(negedge clk); start_s = 1'b1;
      @(negedge clk); start_s = 1'b0;
      for (int k = 1; k <= SC; k++) begin
         @(negedge clk);
         if (k == SF) begin
            chk({name, " R4 floor done"}, W'(done_f), 1);
            chk({name, " R5 floor total"}, sum_f, exp);
         end else begin
            chk({name, " R4 floor done timing"}, W'(done_f), 0);
         end
         if (k == SC) begin
            chk({name, " R6 ceil done"}, W'(done_c), 1);
            chk({name, " R6 ceil total"}, sum_c, exp);
         end else begin
            chk({name, " R6 ceil busy"}, W'(busy_c), 1);
         end
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #400000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 busy", W'(busy_m), 0);
      chk("R1 done", W'(done_m), 0);
      chk("R1 small busy", W'(busy_f | busy_c), 0);

      for (int i = 0; i < NM; i++) dm[i] = W'(i + 1);
      run_main("ascending", 0);

      // R5: only leftover lanes (count 25 -> lane 24, count 3 -> lane 2)
      for (int i = 0; i < NM; i++) dm[i] = '0;
      dm[24] = 32'h0000_0100;
      dm[2]  = 32'h0000_0007;
      run_main("leftover R5", 0);

      // R10 wrap
      for (int i = 0; i < NM; i++) dm[i] = 32'h7FFF_FFFF;
      run_main("wrap R10", 0);
      chk("R10 wrap constant", sum_m, 32'hFFFF_FF9C);

      // R8 start during run
      for (int i = 0; i < NM; i++) dm[i] = W'(3 * i) ^ 32'hA5A5_0000;
      run_main("ignore R8", 2);

      for (int i = 0; i < NS; i++) ds[i] = '0;
      ds[6] = 32'h0000_0005;
      ds[2] = 32'h0000_0700;
      run_small("small leftover");

      for (int i = 0; i < NS; i++) ds[i] = W'(i * 11 + 1) - 32'd20;
      run_small("small mixed");

      finish_run();
   end

endmodule